// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the run, idle and power-down modes of a small microcontroller core. Software raises an idle or power-down request with a one-cycle strobe; the controller then gates the CPU clock, the peripheral clock and the oscillator according to the chosen mode. It also decides which events bring the device back to full operation. Idle is left on any enabled interrupt or on a hardware reset. Power-down stops the oscillator, and only the hardware reset pin can end it.

The external reset pin passes through a synchronizer. While the oscillator runs, the pin is accepted as a reset only after it has been seen high for a full qualification window, which is a parameterised number of machine cycles. When the pin rises during idle, execution resumes at once, with internal RAM writes blocked, until qualification completes. When the pin rises during power-down, the oscillator is restarted. The internal reset is then held through a parameterised start-up period before the CPU clock may run again. RAM retention is signalled whenever the RAM clock domain is frozen or the core is held in reset, so that RAM contents survive both.

Top module: `lpm_power_ctrl`

## Requirements
- R1: After power-on reset (rst_n low) the block is in run mode: cpu_clk_en, per_clk_en and osc_en are 1; int_rst, ram_hold and ram_wr_block are 0; idle_flag and pdown_flag are 0.
- R2: A req_idle strobe in run mode enters idle one cycle later: cpu_clk_en=0, per_clk_en=1, osc_en=1, idle_flag=1.
- R3: In idle, when (irq_pend & irq_en) is non-zero at a clock edge, run mode resumes after that edge and idle_flag clears; a pending interrupt whose enable bit is 0 leaves idle unchanged.
- R4: A req_pdown strobe in run mode enters power-down one cycle later: cpu_clk_en, per_clk_en and osc_en all 0, pdown_flag=1. When req_pdown and req_idle arrive together, power-down wins and idle_flag stays 0.
- R5: In power-down, interrupts have no effect; the block stays in power-down until the synchronized reset pin is high.
- R6: In run, idle or reset-window mode, int_rst rises only after the synchronized pin has been high for QUAL = OSC_PER_MC*RST_QUAL_MC consecutive clocks (24 by default). A pin held high for K clock edges reaches int_rst after edge QUAL+SYNC_STAGES if K >= QUAL; K < QUAL causes no reset.
- R7: When the synchronized pin is high in idle, the block leaves idle after SYNC_STAGES+1 edges into a reset window with cpu_clk_en=1, per_clk_en=1 and ram_wr_block=1. The window either ends in int_rst when qualification completes, or returns to run mode (ram_wr_block=0) when the pin falls first.
- R8: When the synchronized pin is high in power-down, osc_en and int_rst become 1 after SYNC_STAGES+1 edges. The CPU clock stays off for at least STARTUP_CYC further cycles, even if the pin has already fallen.
- R9: While int_rst=1, cpu_clk_en=0, per_clk_en=0, osc_en=1, and both request flags are 0. The block returns to run mode SYNC_STAGES+1 edges after the pin falls, once any start-up wait has ended.
- R10: ram_hold is 1 in power-down, during oscillator start-up and during internal reset, and 0 in run and idle modes. ram_wr_block is 1 whenever ram_hold is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| hw_rst_pin | input | 1 | External reset pin, active high, asynchronous |
| req_idle | input | 1 | Software idle request strobe |
| req_pdown | input | 1 | Software power-down request strobe |
| irq_pend | input | NUM_IRQ | Pending interrupt requests |
| irq_en | input | NUM_IRQ | Interrupt enable mask |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral (timers, serial, interrupt logic) clock enable |
| osc_en | output | 1 | Oscillator enable |
| int_rst | output | 1 | Synchronous internal reset to the core |
| ram_hold | output | 1 | RAM retention / hold indication |
| ram_wr_block | output | 1 | Blocks writes to internal RAM |
| idle_flag | output | 1 | Idle request bit, cleared on exit |
| pdown_flag | output | 1 | Power-down request bit, cleared on exit |

## Verification
The assertions check on every cycle the clock pattern that goes with each request flag and with internal reset. They also check that power-down and idle stay put when no valid wake event arrives, that an enabled interrupt always ends idle, and that an internal reset starting from a running oscillator follows a full window of high pin samples. Only the bench scenarios show the exact cycle counts: synchronizer latency, the qualification boundary at QUAL and QUAL-1 samples, the start-up wait after a one-cycle pin pulse, and the timing of the reset-window release. Random episodes mix interrupt and mask patterns with short pin pulses to show that masked interrupts and sub-threshold pulses leave the mode unchanged.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [2:0] {
      PM_RUN    = 3'd0,
      PM_IDLE   = 3'd1,
      PM_RSTWIN = 3'd2,
      PM_PDOWN  = 3'd3,
      PM_WAKE   = 3'd4,
      PM_RESET  = 3'd5
   } pm_state_e;

   // counter width able to hold values 0 .. n-1
   function automatic int unsigned cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= d;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/lpm_win_cnt.sv
module lpm_win_cnt #(
   parameter int LIMIT = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int W = lpm_pkg::cnt_w(LIMIT);
   localparam logic [W-1:0] LAST = W'(LIMIT - 1);

   logic [W-1:0] cnt;

   // counts consecutive cycles with run high; any gap restarts it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
   end

   assign done = run && (cnt == LAST);
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
   import lpm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req_idle,
   input  logic      req_pdown,
   input  logic      irq_hit,
   input  logic      pin_s,
   input  logic      qual_done,
   input  logic      wake_done,
   output pm_state_e state,
   output logic      idle_flag,
   output logic      pdown_flag
);
   pm_state_e nxt;

   always_comb begin
      nxt = state;
      case (state)
         PM_RUN: begin
            if (qual_done)      nxt = PM_RESET;
            else if (req_pdown) nxt = PM_PDOWN;   // power-down has priority
            else if (req_idle)  nxt = PM_IDLE;
         end
         PM_IDLE: begin
            if (qual_done)      nxt = PM_RESET;
            else if (pin_s)     nxt = PM_RSTWIN;
            else if (irq_hit)   nxt = PM_RUN;
         end
         PM_RSTWIN: begin
            if (qual_done)      nxt = PM_RESET;
            else if (!pin_s)    nxt = PM_RUN;
         end
         PM_PDOWN: begin
            if (pin_s)          nxt = PM_WAKE;
         end
         PM_WAKE: begin
            if (wake_done)      nxt = PM_RESET;
         end
         PM_RESET: begin
            if (!pin_s)         nxt = PM_RUN;
         end
         default:               nxt = PM_RESET;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= PM_RUN;
         idle_flag  <= 1'b0;
         pdown_flag <= 1'b0;
      end else begin
         state      <= nxt;
         idle_flag  <= (nxt == PM_IDLE);
         pdown_flag <= (nxt == PM_PDOWN);
      end
   end
endmodule

// File: rtl/lpm_out_dec.sv
module lpm_out_dec
   import lpm_pkg::*;
(
   input  pm_state_e state,
   output logic      cpu_clk_en,
   output logic      per_clk_en,
   output logic      osc_en,
   output logic      int_rst,
   output logic      ram_hold,
   output logic      ram_wr_block,
   output logic      qual_active,
   output logic      waking
);
   always_comb begin
      cpu_clk_en   = 1'b0;
      per_clk_en   = 1'b0;
      osc_en       = 1'b1;
      int_rst      = 1'b0;
      ram_hold     = 1'b0;
      ram_wr_block = 1'b0;
      qual_active  = 1'b0;
      waking       = 1'b0;
      case (state)
         PM_RUN: begin
            cpu_clk_en  = 1'b1;
            per_clk_en  = 1'b1;
            qual_active = 1'b1;
         end
         PM_IDLE: begin
            per_clk_en  = 1'b1;
            qual_active = 1'b1;
         end
         PM_RSTWIN: begin
            cpu_clk_en   = 1'b1;
            per_clk_en   = 1'b1;
            ram_wr_block = 1'b1;
            qual_active  = 1'b1;
         end
         PM_PDOWN: begin
            osc_en       = 1'b0;
            ram_hold     = 1'b1;
            ram_wr_block = 1'b1;
         end
         PM_WAKE: begin
            int_rst      = 1'b1;
            ram_hold     = 1'b1;
            ram_wr_block = 1'b1;
            waking       = 1'b1;
         end
         default: begin
            int_rst      = 1'b1;
            ram_hold     = 1'b1;
            ram_wr_block = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/lpm_power_ctrl.sv
module lpm_power_ctrl
   import lpm_pkg::*;
#(
   parameter int OSC_PER_MC  = 12,
   parameter int RST_QUAL_MC = 2,
   parameter int SYNC_STAGES = 2,
   parameter int STARTUP_CYC = 64,
   parameter int NUM_IRQ     = 5
) (
   input  logic               clk_osc,
   input  logic               rst_n,
   input  logic               hw_rst_pin,
   input  logic               req_idle,
   input  logic               req_pdown,
   input  logic [NUM_IRQ-1:0] irq_pend,
   input  logic [NUM_IRQ-1:0] irq_en,
   output logic               cpu_clk_en,
   output logic               per_clk_en,
   output logic               osc_en,
   output logic               int_rst,
   output logic               ram_hold,
   output logic               ram_wr_block,
   output logic               idle_flag,
   output logic               pdown_flag
);
   localparam int QUAL = OSC_PER_MC * RST_QUAL_MC;

   generate
      if (OSC_PER_MC < 1)  begin : g_bad_mc    $error("OSC_PER_MC must be >= 1");  end
      if (RST_QUAL_MC < 1) begin : g_bad_qual  $error("RST_QUAL_MC must be >= 1"); end
      if (SYNC_STAGES < 1) begin : g_bad_sync  $error("SYNC_STAGES must be >= 1"); end
      if (STARTUP_CYC < 1) begin : g_bad_start $error("STARTUP_CYC must be >= 1"); end
      if (NUM_IRQ < 1)     begin : g_bad_irq   $error("NUM_IRQ must be >= 1");     end
   endgenerate

   pm_state_e state;
   logic      pin_s;
   logic      irq_hit;
   logic      qual_active;
   logic      waking;
   logic      qual_done;
   logic      wake_done;

   assign irq_hit = |(irq_pend & irq_en);

   lpm_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
      .clk   (clk_osc),
      .rst_n (rst_n),
      .d     (hw_rst_pin),
      .q     (pin_s)
   );

   lpm_win_cnt #(.LIMIT(QUAL)) u_qual_cnt (
      .clk   (clk_osc),
      .rst_n (rst_n),
      .run   (pin_s && qual_active),
      .done  (qual_done)
   );

   lpm_win_cnt #(.LIMIT(STARTUP_CYC)) u_start_cnt (
      .clk   (clk_osc),
      .rst_n (rst_n),
      .run   (waking),
      .done  (wake_done)
   );

   lpm_fsm u_fsm (
      .clk        (clk_osc),
      .rst_n      (rst_n),
      .req_idle   (req_idle),
      .req_pdown  (req_pdown),
      .irq_hit    (irq_hit),
      .pin_s      (pin_s),
      .qual_done  (qual_done),
      .wake_done  (wake_done),
      .state      (state),
      .idle_flag  (idle_flag),
      .pdown_flag (pdown_flag)
   );

   lpm_out_dec u_dec (
      .state        (state),
      .cpu_clk_en   (cpu_clk_en),
      .per_clk_en   (per_clk_en),
      .osc_en       (osc_en),
      .int_rst      (int_rst),
      .ram_hold     (ram_hold),
      .ram_wr_block (ram_wr_block),
      .qual_active  (qual_active),
      .waking       (waking)
   );
endmodule

// File: rtl/lpm_power_ctrl_chk.sv
module lpm_power_ctrl_chk #(
   parameter int QUAL    = 24,
   parameter int NUM_IRQ = 5
) (
   input logic               clk_osc,
   input logic               rst_n,
   input logic               req_idle,
   input logic               req_pdown,
   input logic [NUM_IRQ-1:0] irq_pend,
   input logic [NUM_IRQ-1:0] irq_en,
   input logic               pin_s,
   input logic               cpu_clk_en,
   input logic               per_clk_en,
   input logic               osc_en,
   input logic               int_rst,
   input logic               ram_hold,
   input logic               ram_wr_block,
   input logic               idle_flag,
   input logic               pdown_flag
);
   localparam int HW = lpm_pkg::cnt_w(QUAL + 2);
   localparam logic [HW-1:0] QV = HW'(QUAL);

   logic          hit;
   logic          in_run;
   logic [HW-1:0] hi_cnt;

   assign hit    = |(irq_pend & irq_en);
   assign in_run = cpu_clk_en && !ram_wr_block;

   // consecutive high pin samples while the oscillator runs outside reset
   always_ff @(posedge clk_osc or negedge rst_n) begin
      if (!rst_n)                              hi_cnt <= '0;
      else if (!(pin_s && osc_en && !int_rst)) hi_cnt <= '0;
      else if (hi_cnt != QV)                   hi_cnt <= hi_cnt + 1'b1;
   end

   AST_IDLE_CLOCKS: assert property (@(posedge clk_osc) disable iff (!rst_n)
      idle_flag |-> (!cpu_clk_en && per_clk_en && osc_en)); // R2
   AST_IDLE_ENTRY: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (in_run && req_idle && !req_pdown && !pin_s) |=> idle_flag); // R2
   AST_IRQ_WAKE: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (idle_flag && hit && !pin_s) |=> (cpu_clk_en && !idle_flag)); // R3
   AST_IDLE_HOLD: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (idle_flag && !hit && !pin_s) |=> idle_flag); // R3
   AST_PD_ALL_OFF: assert property (@(posedge clk_osc) disable iff (!rst_n)
      pdown_flag |-> (!osc_en && !cpu_clk_en && !per_clk_en)); // R4
   AST_PD_PRIORITY: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (in_run && req_pdown && !pin_s) |=> (pdown_flag && !idle_flag)); // R4
   AST_FLAGS_EXCL: assert property (@(posedge clk_osc) disable iff (!rst_n)
      !(idle_flag && pdown_flag)); // R4
   AST_PD_STAYS: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (pdown_flag && !pin_s) |=> pdown_flag); // R5
   AST_RST_QUALIFIED: assert property (@(posedge clk_osc) disable iff (!rst_n)
      ($rose(int_rst) && $past(osc_en)) |-> (hi_cnt >= QV)); // R6
   AST_OSC_RESTART: assert property (@(posedge clk_osc) disable iff (!rst_n)
      $rose(osc_en) |-> (int_rst && !cpu_clk_en)); // R8
   AST_RST_CLOCKS: assert property (@(posedge clk_osc) disable iff (!rst_n)
      int_rst |-> (!cpu_clk_en && !per_clk_en && osc_en && !idle_flag && !pdown_flag)); // R9
   AST_RST_RETAIN: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (int_rst || !osc_en) |-> ram_hold); // R10
   AST_HOLD_BLOCKS: assert property (@(posedge clk_osc) disable iff (!rst_n)
      ram_hold |-> ram_wr_block); // R10
endmodule

bind lpm_power_ctrl lpm_power_ctrl_chk #(.QUAL(QUAL), .NUM_IRQ(NUM_IRQ)) u_chk (
   .clk_osc      (clk_osc),
   .rst_n        (rst_n),
   .req_idle     (req_idle),
   .req_pdown    (req_pdown),
   .irq_pend     (irq_pend),
   .irq_en       (irq_en),
   .pin_s        (pin_s),
   .cpu_clk_en   (cpu_clk_en),
   .per_clk_en   (per_clk_en),
   .osc_en       (osc_en),
   .int_rst      (int_rst),
   .ram_hold     (ram_hold),
   .ram_wr_block (ram_wr_block),
   .idle_flag    (idle_flag),
   .pdown_flag   (pdown_flag)
);

// File: tb/lpm_power_ctrl_bench.sv
module lpm_power_ctrl_bench;
   localparam int OPM     = 12;
   localparam int QMC     = 2;
   localparam int SYNC    = 2;
   localparam int STARTUP = 40;
   localparam int NIRQ    = 5;
   localparam int QUAL    = OPM * QMC;

   // bench mode codes
   localparam int M_RUN = 0, M_IDLE = 1, M_WIN = 2, M_PD = 3, M_WAKE = 4, M_RST = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            pin = 1'b0;
   logic            r_idle = 1'b0;
   logic            r_pd = 1'b0;
   logic [NIRQ-1:0] pend = '0;
   logic [NIRQ-1:0] en = '0;
   logic cpu, per, osc, irst, hold, blk, fi, fp;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   lpm_power_ctrl #(
      .OSC_PER_MC(OPM), .RST_QUAL_MC(QMC), .SYNC_STAGES(SYNC),
      .STARTUP_CYC(STARTUP), .NUM_IRQ(NIRQ)
   ) u_lpm_power_ctrl (
      .clk_osc(clk), .rst_n(rst_n), .hw_rst_pin(pin),
      .req_idle(r_idle), .req_pdown(r_pd), .irq_pend(pend), .irq_en(en),
      .cpu_clk_en(cpu), .per_clk_en(per), .osc_en(osc), .int_rst(irst),
      .ram_hold(hold), .ram_wr_block(blk), .idle_flag(fi), .pdown_flag(fp)
   );

   wire [5:0] obs = {cpu, per, osc, irst, hold, blk};

   // expected {cpu, per, osc, int_rst, ram_hold, ram_wr_block} per mode
   function automatic logic [5:0] exp_vec(input int m);
      case (m)
         M_RUN:  return 6'b111000;
         M_IDLE: return 6'b011000;
         M_WIN:  return 6'b111001;
         M_PD:   return 6'b000011;
         default: return 6'b001111;   // start-up wait and reset look alike
      endcase
   endfunction

   function automatic bit exp_wake(input logic [NIRQ-1:0] p, input logic [NIRQ-1:0] e);
      return |(p & e);
   endfunction

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%b exp=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_mode(input string tag, input int m);
      chk(tag, obs, exp_vec(m));
   endtask

   task automatic chk_flags(input string tag, input logic [1:0] exp);
      chk(tag, {4'b0, fi, fp}, {4'b0, exp});
   endtask

   task automatic go_idle();
      r_idle = 1'b1; step(1); r_idle = 1'b0;
   endtask

   task automatic go_pd();
      r_pd = 1'b1; step(1); r_pd = 1'b0;
   endtask

   // one-cycle pin pulse in power-down, then start-up and release
   task automatic wake_from_pd(input string tag);
      pin = 1'b1; step(1); pin = 1'b0;
      step(1);          chk_mode({tag, " R8 still off"}, M_PD);
      step(1);          chk_mode({tag, " R8 osc restart"}, M_WAKE);
      step(STARTUP);    chk_mode({tag, " R8 held through start-up"}, M_RST);
      step(1);          chk_mode({tag, " R9 release to run"}, M_RUN);
      chk_flags({tag, " R9 flags clear"}, 2'b00);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step(2);
      chk_mode("R1 reset state", M_RUN);
      chk_flags("R1 flags", 2'b00);

      // R2 idle entry
      go_idle();
      chk_mode("R2 idle clocks", M_IDLE);
      chk_flags("R2 idle flag", 2'b10);

      // R3 masked interrupt ignored, enabled one wakes
      pend = 5'b00100; en = 5'b11011;
      step(4);
      chk_mode("R3 masked irq ignored", M_IDLE);
      en = 5'b00100;
      step(1);
      chk_mode("R3 enabled irq wakes", M_RUN);
      chk_flags("R3 idle flag cleared", 2'b00);
      pend = '0; en = '0;

      // R4 simultaneous requests: power-down wins
      r_idle = 1'b1; r_pd = 1'b1; step(1); r_idle = 1'b0; r_pd = 1'b0;
      chk_mode("R4 power-down clocks", M_PD);
      chk_flags("R4 priority flags", 2'b01);

      // R5 interrupts ignored in power-down
      pend = '1; en = '1;
      step(6);
      chk_mode("R5 irq ignored in power-down", M_PD);
      chk_flags("R5 flag kept", 2'b01);
      pend = '0; en = '0;

      // R8 wake by pin
      wake_from_pd("dir");

      // R6 qualification boundary: QUAL-1 samples ignored
      pin = 1'b1; step(QUAL - 1); pin = 1'b0;
      step(SYNC + 3);
      chk_mode("R6 QUAL-1 samples ignored", M_RUN);

      // R6 exactly QUAL samples qualify
      pin = 1'b1; step(QUAL); pin = 1'b0;
      step(SYNC);
      chk_mode("R6 QUAL samples reset", M_RST);
      step(1);
      chk_mode("R9 short reset released", M_RUN);

      // R6/R9 held pin: exact rise and release timing
      pin = 1'b1;
      step(QUAL + SYNC - 1);
      chk_mode("R6 not yet qualified", M_RUN);
      step(1);
      chk_mode("R6 qualified reset", M_RST);
      step(10);
      chk_mode("R9 held while pin high", M_RST);
      pin = 1'b0;
      step(SYNC);
      chk_mode("R9 still in reset", M_RST);
      step(1);
      chk_mode("R9 back to run", M_RUN);

      // R7 pin in idle, full qualification
      go_idle();
      pin = 1'b1;
      step(SYNC);
      chk_mode("R7 idle before sync", M_IDLE);
      step(1);
      chk_mode("R7 reset window", M_WIN);
      chk_flags("R7 idle flag cleared", 2'b00);
      step(QUAL - 2);
      chk_mode("R7 window before qual", M_WIN);
      step(1);
      chk_mode("R7 window ends in reset", M_RST);
      pin = 1'b0;
      step(SYNC + 1);
      chk_mode("R9 run after window reset", M_RUN);

      // R7 pin falls during the window
      go_idle();
      pin = 1'b1; step(SYNC + 1);
      chk_mode("R7 window opened", M_WIN);
      pin = 1'b0;
      step(SYNC);
      chk_mode("R7 window persists", M_WIN);
      step(1);
      chk_mode("R7 window abandoned", M_RUN);
      chk_flags("R7 flags after abandon", 2'b00);

      // random episodes
      for (int i = 0; i < 40; i++) begin
         int kind;
         kind = int'($urandom_range(2, 0));
         if (kind == 0) begin
            logic [NIRQ-1:0] p;
            logic [NIRQ-1:0] e;
            p = NIRQ'($urandom);
            e = NIRQ'($urandom);
            go_idle();
            step(int'($urandom_range(4, 1)));
            chk_mode("R3 rnd idle holds", M_IDLE);
            pend = p; en = e;
            step(1);
            chk_mode("R3 rnd irq mask", exp_wake(p, e) ? M_RUN : M_IDLE);
            if (!exp_wake(p, e)) begin
               pend = 5'b00001; en = 5'b00001;
               step(1);
               chk_mode("R3 rnd forced wake", M_RUN);
            end
            pend = '0; en = '0;
         end else if (kind == 1) begin
            pin = 1'b1;
            step(int'($urandom_range(QUAL - 1, 1)));
            pin = 1'b0;
            step(SYNC + 2);
            chk_mode("R6 rnd short pulse", M_RUN);
         end else begin
            go_pd();
            pend = NIRQ'($urandom); en = NIRQ'($urandom);
            step(int'($urandom_range(8, 1)));
            chk_mode("R5 rnd power-down holds", M_PD);
            pend = '0; en = '0;
            wake_from_pd("rnd");
         end
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule